// File: doc/BRIEF.md
# GPIO controller with per-pin interrupts

A memory-mapped general-purpose I/O block for up to 31 pins. Software programs it through a simple 32-bit register bus. Writes take effect on the clock edge where the write strobe is high. A read returns its data on `rd_data_o` after the edge where the read strobe is high, and that value holds until the next read.

Each pin has an output value, an output-enable and an input. The output value is never written directly. Software sets bits through a write-one-to-set register and clears them through a write-one-to-clear register. Inputs pass through a two-flop synchroniser before they reach the readable input register and the interrupt detectors.

Every pin has its own interrupt cell. The cell is either level or edge sensitive, and the polarity is programmable. Its pending bit is gated by an enable register. A separate mask register decides which pending bits reach the single registered interrupt output. A build parameter inverts the sense of the direction register.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset, the output values are 0, the direction, enable, type, polarity and mask registers read 0, the pending register reads 0, and `irq_o` is 0.
- R2: The byte offsets are 0x00 direction, 0x04 input, 0x0C set, 0x10 clear, 0x14 enable, 0x18 type, 0x1C polarity, 0x20 pending and 0x24 mask. The direction, enable, type, polarity and mask registers read back the last value written, with bits at or above NUM_PINS returning 0. Reads at 0x0C and 0x10 return the current output values. Reads at any other offset return 0.
- R3: Writing to 0x0C sets the output bits given as ones, and writing to 0x10 clears them. Zero bits leave the output unchanged. Without such a write, `pin_out_o` does not change.
- R4: With DIR_INV=0, `pin_oe_o` equals the direction register. With DIR_INV=1, it is that register's bitwise inverse. It changes only on a write to 0x00.
- R5: The input register (0x04) returns the pin levels after a two-flop synchroniser. A level held for two clock edges is readable.
- R6: A type bit of 0 selects level mode. In level mode the pending bit is 1 while the enabled pin's synchronised level equals its polarity bit (1 = high, 0 = low). Writes to pending have no effect on a level-mode pin.
- R7: A type bit of 1 selects edge mode. In edge mode the pending bit latches on a rising edge when the polarity bit is 1, or on a falling edge when it is 0. It stays set after the pin returns, until a one is written to that bit at 0x20. An edge of the opposite direction does not set it.
- R8: `irq_o` is a register holding the OR over all pins of pending AND mask. A pending pin with its mask bit at 0 does not raise `irq_o`. `irq_o` falls in the cycle after the last contributing bit clears.
- R9: A pin whose enable bit is 0 reads 0 in pending. Clearing an enable bit also discards a latched edge, so re-enabling the pin does not bring back an old pending bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Register byte offset |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | 32 | Write data |
| rd_en_i | input | 1 | Read strobe |
| rd_data_o | output | 32 | Read data, registered |
| pin_in_i | input | NUM_PINS | Pin input levels |
| pin_out_o | output | NUM_PINS | Pin output values |
| pin_oe_o | output | NUM_PINS | Pin output enables, 1 = drive |
| irq_o | output | 1 | Combined interrupt |

## Verification
Every cycle, the assertions check four things:
- a set or clear write reaches `pin_out_o` on the next edge, and the outputs stay still without such a write;
- the output-enables move only after a direction write;
- clearing an enable bit empties that pin's pending bit at once;
- `irq_o` rises only when some pin is both enabled and unmasked.

Only the bench's scenarios can show the rest:
- the two-stage input latency, swept over all input patterns;
- the edge-versus-level and polarity behaviour of each pin;
- that a latched edge persists until cleared, and that opposite edges are ignored;
- the one-cycle deassert of `irq_o` after a mask change;
- the inverted direction build.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int unsigned OFF_DIR   = 'h00;
  localparam int unsigned OFF_IN    = 'h04;
  localparam int unsigned OFF_SET   = 'h0C;
  localparam int unsigned OFF_CLR   = 'h10;
  localparam int unsigned OFF_IEN   = 'h14;
  localparam int unsigned OFF_ITYPE = 'h18;
  localparam int unsigned OFF_IPOL  = 'h1C;
  localparam int unsigned OFF_IPEND = 'h20;
  localparam int unsigned OFF_IMASK = 'h24;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o,
  output logic [W-1:0] prev_o
);
  logic [W-1:0] meta_q, sync_q, prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign q_o    = sync_q;
  assign prev_o = prev_q;
endmodule

// File: rtl/gpio_irq_slice.sv
module gpio_irq_slice (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cur_i,
  input  logic prev_i,
  input  logic en_i,
  input  logic edge_i,
  input  logic pol_i,
  input  logic ack_i,
  output logic pend_o
);
  logic lvl_hit, edge_hit, lat_q;

  assign lvl_hit  = (cur_i == pol_i);
  assign edge_hit = pol_i ? (cur_i & ~prev_i) : (~cur_i & prev_i);

  // a new edge wins over a simultaneous acknowledge so no event is lost
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                lat_q <= 1'b0;
    else if (!en_i || !edge_i)  lat_q <= 1'b0;
    else if (edge_hit)          lat_q <= 1'b1;
    else if (ack_i)             lat_q <= 1'b0;
  end

  assign pend_o = en_i & (edge_i ? lat_q : lvl_hit);
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NUM_PINS = 8,
  parameter bit          DIR_INV  = 1'b0,
  parameter int unsigned ADDR_W   = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic                wr_en_i,
  input  logic [31:0]         wr_data_i,
  input  logic                rd_en_i,
  output logic [31:0]         rd_data_o,
  input  logic [NUM_PINS-1:0] pin_in_i,
  output logic [NUM_PINS-1:0] pin_out_o,
  output logic [NUM_PINS-1:0] pin_oe_o,
  output logic                irq_o
);
  localparam int unsigned N = NUM_PINS;

  logic [N-1:0] dir_q, out_q, ien_q, ityp_q, ipol_q, imask_q;
  logic [N-1:0] wd, cur_w, prev_w, pend_w;
  logic         irq_q;
  logic [31:0]  rdata_d, rdata_q;
  logic         unused_wr_hi;

  assign wd           = wr_data_i[N-1:0];
  assign unused_wr_hi = ^wr_data_i[31:N];

  function automatic logic hit(input logic [ADDR_W-1:0] a, input int unsigned off);
    return a == ADDR_W'(off);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q   <= '0;
      out_q   <= '0;
      ien_q   <= '0;
      ityp_q  <= '0;
      ipol_q  <= '0;
      imask_q <= '0;
    end else if (wr_en_i) begin
      if (hit(addr_i, OFF_DIR))   dir_q   <= wd;
      if (hit(addr_i, OFF_SET))   out_q   <= out_q | wd;
      if (hit(addr_i, OFF_CLR))   out_q   <= out_q & ~wd;
      if (hit(addr_i, OFF_IEN))   ien_q   <= wd;
      if (hit(addr_i, OFF_ITYPE)) ityp_q  <= wd;
      if (hit(addr_i, OFF_IPOL))  ipol_q  <= wd;
      if (hit(addr_i, OFF_IMASK)) imask_q <= wd;
    end
  end

  gpio_in_sync #(.W(N)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pin_in_i),
    .q_o    (cur_w),
    .prev_o (prev_w)
  );

  logic ack_wr;
  assign ack_wr = wr_en_i && hit(addr_i, OFF_IPEND);

  for (genvar g = 0; g < N; g++) begin : g_pin
    gpio_irq_slice u_slice (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .cur_i  (cur_w[g]),
      .prev_i (prev_w[g]),
      .en_i   (ien_q[g]),
      .edge_i (ityp_q[g]),
      .pol_i  (ipol_q[g]),
      .ack_i  (ack_wr && wd[g]),
      .pend_o (pend_w[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= |(pend_w & imask_q);
  end

  always_comb begin
    rdata_d = '0;
    if      (hit(addr_i, OFF_DIR))   rdata_d[N-1:0] = dir_q;
    else if (hit(addr_i, OFF_IN))    rdata_d[N-1:0] = cur_w;
    else if (hit(addr_i, OFF_SET))   rdata_d[N-1:0] = out_q;
    else if (hit(addr_i, OFF_CLR))   rdata_d[N-1:0] = out_q;
    else if (hit(addr_i, OFF_IEN))   rdata_d[N-1:0] = ien_q;
    else if (hit(addr_i, OFF_ITYPE)) rdata_d[N-1:0] = ityp_q;
    else if (hit(addr_i, OFF_IPOL))  rdata_d[N-1:0] = ipol_q;
    else if (hit(addr_i, OFF_IPEND)) rdata_d[N-1:0] = pend_w;
    else if (hit(addr_i, OFF_IMASK)) rdata_d[N-1:0] = imask_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdata_q <= '0;
    else if (rd_en_i) rdata_q <= rdata_d;
  end

  assign rd_data_o = rdata_q;
  assign pin_out_o = out_q;
  assign pin_oe_o  = DIR_INV ? ~dir_q : dir_q;
  assign irq_o     = irq_q;
endmodule

// File: rtl/gpio_irq_ctrl_chk.sv
module gpio_irq_ctrl_chk
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NUM_PINS = 8,
  parameter int unsigned ADDR_W   = 8
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [ADDR_W-1:0]   addr_i,
  input logic                wr_en_i,
  input logic [31:0]         wr_data_i,
  input logic [NUM_PINS-1:0] pin_out_o,
  input logic [NUM_PINS-1:0] pin_oe_o,
  input logic                irq_o,
  input logic [NUM_PINS-1:0] pend_i,
  input logic [NUM_PINS-1:0] ien_i,
  input logic [NUM_PINS-1:0] imask_i
);
  localparam int unsigned N = NUM_PINS;

  logic wr_set, wr_clr, wr_dir, wr_ien;
  assign wr_set = wr_en_i && addr_i == ADDR_W'(OFF_SET);
  assign wr_clr = wr_en_i && addr_i == ADDR_W'(OFF_CLR);
  assign wr_dir = wr_en_i && addr_i == ADDR_W'(OFF_DIR);
  assign wr_ien = wr_en_i && addr_i == ADDR_W'(OFF_IEN);

  a_r3_set_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_set |=> ((pin_out_o & $past(wr_data_i[N-1:0])) == $past(wr_data_i[N-1:0])));

  a_r3_clr_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_clr |=> ((pin_out_o & $past(wr_data_i[N-1:0])) == '0));

  a_r3_out_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_set || wr_clr) |=> $stable(pin_out_o));

  a_r4_oe_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_dir |=> $stable(pin_oe_o));

  a_r9_disable_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ien |=> ((pend_i & ~$past(wr_data_i[N-1:0])) == '0));

  a_r8_irq_needs_unmasked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(|(ien_i & imask_i)));
endmodule

bind gpio_irq_ctrl gpio_irq_ctrl_chk #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .addr_i    (addr_i),
  .wr_en_i   (wr_en_i),
  .wr_data_i (wr_data_i),
  .pin_out_o (pin_out_o),
  .pin_oe_o  (pin_oe_o),
  .irq_o     (irq_o),
  .pend_i    (pend_w),
  .ien_i     (ien_q),
  .imask_i   (imask_q)
);

// File: tb/gpio_irq_ctrl_tb.sv
module gpio_irq_ctrl_tb;
  localparam int unsigned N = 8;
  localparam int unsigned AW = 8;
  localparam logic [31:0] M = 32'h0000_00FF;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          wr_en = 1'b0, rd_en = 1'b0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata, rdata_inv;
  logic [N-1:0]  pins = '0;
  logic [N-1:0]  pout, poe, pout_inv, poe_inv;
  logic          irq, irq_inv;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  gpio_irq_ctrl #(.NUM_PINS(N), .DIR_INV(1'b0), .ADDR_W(AW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(wr_en), .wr_data_i(wdata),
    .rd_en_i(rd_en), .rd_data_o(rdata), .pin_in_i(pins), .pin_out_o(pout),
    .pin_oe_o(poe), .irq_o(irq));

  gpio_irq_ctrl #(.NUM_PINS(N), .DIR_INV(1'b1), .ADDR_W(AW)) u_dut_inv (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(wr_en), .wr_data_i(wdata),
    .rd_en_i(rd_en), .rd_data_o(rdata_inv), .pin_in_i(pins), .pin_out_o(pout_inv),
    .pin_oe_o(poe_inv), .irq_o(irq_inv));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  initial begin : wdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] r, model;
    logic [AW-1:0] cfg [5];
    logic [31:0] pats [4];
    cfg[0] = 8'h00; cfg[1] = 8'h14; cfg[2] = 8'h18; cfg[3] = 8'h1C; cfg[4] = 8'h24;
    pats[0] = 32'hFFFF_FFFF; pats[1] = 32'hA5A5_A5A5; pats[2] = 32'h0000_005A; pats[3] = 32'h1234_5678;

    tick(3);
    rst_n = 1'b1;
    tick(1);

    // R1 reset state
    chk("R1 pin_out", 32'(pout), 0);
    chk("R1 pin_oe", 32'(poe), 0);
    chk("R1 pin_oe inverted build", 32'(poe_inv), M);
    chk("R1 irq", 32'(irq), 0);
    for (int i = 0; i < 5; i++) begin
      rd(cfg[i], r);
      chk("R1 config reg", r, 0);
    end
    rd(8'h20, r);
    chk("R1 pending", r, 0);

    // R2 readback and R4 direction sense
    foreach (pats[p]) begin
      for (int i = 0; i < 5; i++) begin
        wr(cfg[i], pats[p]);
        rd(cfg[i], r);
        chk("R2 readback", r, pats[p] & M);
        if (i == 0) begin
          chk("R4 oe normal", 32'(poe), pats[p] & M);
          chk("R4 oe inverted", 32'(poe_inv), ~pats[p] & M);
        end
      end
    end
    for (int i = 0; i < 5; i++) wr(cfg[i], 0);
    rd(8'h08, r); chk("R2 unmapped 0x08", r, 0);
    rd(8'h28, r); chk("R2 unmapped 0x28", r, 0);

    // R3 set / clear sweep
    model = 0;
    for (int i = 0; i < 16; i++) begin
      logic [31:0] s, c;
      s = (32'(i) * 37 + 5) & M;
      c = (32'(i) * 91 + 3) & M;
      wr(8'h0C, s | 32'hFF00_0000);
      model = model | s;
      chk("R3 set", 32'(pout), model);
      wr(8'h10, c);
      model = model & ~c;
      chk("R3 clear", 32'(pout), model);
      rd(8'h0C, r);
      chk("R2 out readback", r, model);
    end
    wr(8'h10, M);

    // R5 input register, every pattern
    for (int v = 0; v < 256; v++) begin
      @(negedge clk); pins = N'(v);
      tick(2);
      rd(8'h04, r);
      chk("R5 input", r, 32'(v));
    end
    pins = '0;

    // R6 level mode, active high then active low
    wr(8'h18, 0); wr(8'h1C, M); wr(8'h24, M); wr(8'h14, M);
    tick(3);
    for (int k = 0; k < N; k++) begin
      @(negedge clk); pins = N'(1 << k);
      tick(3);
      rd(8'h20, r);
      chk("R6 level high pending", r, 32'(1 << k));
      chk("R8 irq on", 32'(irq), 1);
      wr(8'h20, M);
      rd(8'h20, r);
      chk("R6 level ignores ack", r, 32'(1 << k));
      @(negedge clk); pins = '0;
      tick(3);
      rd(8'h20, r);
      chk("R6 level release", r, 0);
      chk("R8 irq off", 32'(irq), 0);
    end
    wr(8'h1C, 0);
    @(negedge clk); pins = N'(M);
    tick(3);
    for (int k = 0; k < N; k++) begin
      @(negedge clk); pins = N'(M & ~(32'(1) << k));
      tick(3);
      rd(8'h20, r);
      chk("R6 level low pending", r, 32'(1 << k));
    end

    // R8 mask gating and deassert timing (pin 7 low, active-low level)
    chk("R8 irq before mask", 32'(irq), 1);
    @(negedge clk); addr = 8'h24; wdata = 0; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
    chk("R8 irq one cycle after mask write", 32'(irq), 1);
    @(negedge clk);
    chk("R8 irq dropped", 32'(irq), 0);
    rd(8'h20, r);
    chk("R8 masked still pending", r, 32'h80);
    tick(3);
    chk("R8 masked no irq", 32'(irq), 0);

    // R9 disabled level pin shows no pending
    wr(8'h24, M);
    wr(8'h14, 0);
    rd(8'h20, r);
    chk("R9 disabled level", r, 0);
    tick(2);
    chk("R9 disabled no irq", 32'(irq), 0);

    // R7 rising edge
    @(negedge clk); pins = '0;
    wr(8'h18, M); wr(8'h1C, M); wr(8'h14, M);
    tick(3);
    wr(8'h20, M);
    for (int k = 0; k < N; k++) begin
      @(negedge clk); pins = N'(1 << k);
      tick(4);
      rd(8'h20, r);
      chk("R7 rising latched", r, 32'(1 << k));
      chk("R8 irq edge", 32'(irq), 1);
      @(negedge clk); pins = '0;
      tick(4);
      rd(8'h20, r);
      chk("R7 held after fall", r, 32'(1 << k));
      wr(8'h20, 32'(1 << k));
      rd(8'h20, r);
      chk("R7 ack clears", r, 0);
      chk("R8 irq after ack", 32'(irq), 0);
    end

    // R7 falling edge; rising edges ignored
    wr(8'h1C, 0);
    @(negedge clk); pins = N'(M);
    tick(4);
    rd(8'h20, r);
    chk("R7 rising ignored in falling mode", r, 0);
    for (int k = 0; k < N; k++) begin
      @(negedge clk); pins = N'(M & ~(32'(1) << k));
      tick(4);
      rd(8'h20, r);
      chk("R7 falling latched", r, 32'(1 << k));
      @(negedge clk); pins = N'(M);
      tick(4);
      wr(8'h20, M);
      rd(8'h20, r);
      chk("R7 falling ack", r, 0);
    end

    // R9 disable discards latched edge
    @(negedge clk); pins = N'(M & ~32'h4);
    tick(4);
    rd(8'h20, r);
    chk("R9 latched before disable", r, 32'h4);
    wr(8'h14, M & ~32'h4);
    rd(8'h20, r);
    chk("R9 disabled pending", r, 0);
    wr(8'h14, M);
    rd(8'h20, r);
    chk("R9 no stale pending", r, 0);
    tick(2);
    chk("R9 no irq", 32'(irq), 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule